// File: doc/BRIEF.md
# Hierarchical MSI and Legacy Interrupt Aggregator

This block gathers message-signalled interrupts and the four legacy wired interrupt lines of a PCIe root port and turns them into a single interrupt request for a processor. MSI events arrive as a one-cycle strobe carrying a vector number. The vector space is split into groups: 8 groups of 32 vectors with the default parameters. Each group keeps a pending word, a vector-enable word and a message-address word that software programs. A group whose enabled pending vectors are non-zero, and whose group enable is set, raises a sticky summary bit in a top-level pending word. The legacy lines, three miscellaneous event strobes and the group summaries share that word. It is masked by a top-level enable word to form the interrupt output.

Each legacy line is modelled as a level interrupt by a small state machine with three states. In `INTX_IDLE` nothing is pending. An assert strobe takes `IDLE -> ACTIVE`. In `INTX_ACTIVE` the line is held and clear requests are ignored. A deassert strobe with no assert takes `ACTIVE -> RELEASED`. In `INTX_RELEASED` the bit is still pending and waits for software. A clear takes `RELEASED -> IDLE`, and a new assert takes `RELEASED -> ACTIVE`. An assert takes priority over both a deassert and a clear in the same cycle.

Software reaches every register through a simple register port. Writes take effect at the clock edge where the write is sampled. Reads return data on `reg_rdata_o` one cycle after the read strobe.

Top module: `irqagg_top`

## Requirements
- R1: An MSI strobe with vector V sets bit V%32 of the pending word of group V/32. A group's pending word is read at byte offset 0xC04 + 0x10*group, and the pending bit is visible from the clock edge that samples the strobe.
- R2: Writing ones to a group's pending word clears those bits. When an MSI for a bit arrives in the same cycle as a clear of that bit, the bit stays set.
- R3: Each group has a read/write message-address word at 0xC00 + 0x10*group and a read/write vector-enable word at 0xC08 + 0x10*group. Both are zero after reset.
- R4: The group-enable word at 0x190 holds one bit per group in bits 0..7. Top-level bit 8+g sets one edge after group g has (pending AND vector-enable) non-zero while group-enable bit g is 1. The bit is sticky. Writing 1 to it at 0x184 does not clear it while that condition still holds, and clears it once the condition is gone.
- R5: Legacy line n (0..3 for A..D) shows as top-level bit 24+n from the edge that samples its assert strobe. Writing 1 to that bit has no effect while the line is asserted. A deassert alone leaves the bit set. A write of 1 after the deassert clears it.
- R6: The message, error-report and power-management event strobes set top-level bits 28, 29 and 30. The bits clear when 1 is written to them, and a strobe in the same cycle as the clear keeps the bit set.
- R7: `irq_o` is high exactly when some bit of the top-level pending word at 0x184 is also set in the top-level enable word at 0x180. The enable word stores only bits 8..15 and 24..30.
- R8: After reset every register reads zero and `irq_o` is low.
- R9: Read data appears on `reg_rdata_o` the cycle after `reg_rd_i`. An offset that is not mapped reads zero, and a write to it changes no register. The mapped offsets are 0x180, 0x184, 0x190 and word offsets 0x0/0x4/0x8 inside the group range that starts at 0xC00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, one cycle after the read strobe |
| msi_valid_i | input | 1 | MSI event strobe |
| msi_vector_i | input | 8 | MSI vector number |
| intx_assert_i | input | 4 | Legacy line assert strobes, bit n = line n |
| intx_deassert_i | input | 4 | Legacy line deassert strobes |
| evt_msg_i | input | 1 | Message-received event strobe |
| evt_aer_i | input | 1 | Error-report event strobe |
| evt_pm_i | input | 1 | Power-management event strobe |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The bench targets the races where a set and a clear meet in one cycle, both on a group pending bit and on an event bit. A design that gives the clear priority would lose an interrupt, and the bench would read zero where it expects the bit. It also clears a group summary while that group is still pending. A design that is not sticky, or that obeys the clear, would drop the summary and leave `irq_o` low. For the legacy lines, the bench clears while the line is asserted and again after only a deassert. A design that treats the line as edge-triggered would clear too early and lose the level. The bench also covers the group-enable gate, the top-level mask and unmapped offsets. A design that ignores the gate would raise a summary for a disabled group, and one that decodes offsets loosely would alias an unmapped write onto a live register.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    // Fixed register offsets (bit layout of the top words is behaviour)
    localparam logic [ADDR_W-1:0] OFS_TOP_EN   = 12'h180;
    localparam logic [ADDR_W-1:0] OFS_TOP_STAT = 12'h184;
    localparam logic [ADDR_W-1:0] OFS_GRP_EN   = 12'h190;
    localparam logic [ADDR_W-1:0] OFS_GRP_BASE = 12'hC00;
    localparam int GRP_STRIDE_LG2 = 4;

    // Positions inside the top-level pending/enable words
    localparam int SUM_LSB  = 8;
    localparam int INTX_LSB = 24;
    localparam int EVT_LSB  = 28;
    localparam int NUM_EVT  = 3;

    // Legacy line state
    typedef enum logic [1:0] {
        INTX_IDLE     = 2'd0,
        INTX_ACTIVE   = 2'd1,
        INTX_RELEASED = 2'd2
    } intx_state_e;

    // Word selector inside one group block
    typedef enum logic [1:0] {
        GW_ADDR = 2'd0,
        GW_PEND = 2'd1,
        GW_VEN  = 2'd2,
        GW_NONE = 2'd3
    } grp_word_e;
endpackage

// File: rtl/irqagg_msi_group.sv
module irqagg_msi_group
    import irqagg_pkg::*;
#(
    parameter int VEC_PER_GRP = 32,
    parameter int BIT_W       = $clog2(VEC_PER_GRP)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   hit_i,
    input  logic [BIT_W-1:0]       bit_i,
    input  logic                   wr_sel_i,
    input  grp_word_e              wr_word_i,
    input  logic [DATA_W-1:0]      wdata_i,
    output logic [DATA_W-1:0]      addr_o,
    output logic [VEC_PER_GRP-1:0] pend_o,
    output logic [VEC_PER_GRP-1:0] ven_o,
    output logic                   live_o
);
    logic [DATA_W-1:0]      addr_q;
    logic [VEC_PER_GRP-1:0] pend_q;
    logic [VEC_PER_GRP-1:0] ven_q;
    logic [VEC_PER_GRP-1:0] set_vec;
    logic [VEC_PER_GRP-1:0] clr_vec;

    always_comb begin
        set_vec = '0;
        if (hit_i) begin
            set_vec[bit_i] = 1'b1;
        end
        clr_vec = '0;
        if (wr_sel_i && wr_word_i == GW_PEND) begin
            clr_vec = wdata_i[VEC_PER_GRP-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            pend_q <= '0;
            ven_q  <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_vec) | set_vec;
            if (wr_sel_i && wr_word_i == GW_ADDR) begin
                addr_q <= wdata_i;
            end
            if (wr_sel_i && wr_word_i == GW_VEN) begin
                ven_q <= wdata_i[VEC_PER_GRP-1:0];
            end
        end
    end

    assign addr_o = addr_q;
    assign pend_o = pend_q;
    assign ven_o  = ven_q;
    assign live_o = |(pend_q & ven_q);

    AST_MSI_SETS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        hit_i |=> ((pend_q & $past(set_vec)) == $past(set_vec))); // R1
    AST_CLEAR_LOSES_TO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && wr_sel_i && wr_word_i == GW_PEND) |=> (pend_q & $past(set_vec)) != '0); // R2
endmodule

// File: rtl/irqagg_intx_fsm.sv
module irqagg_intx_fsm
    import irqagg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic assert_i,
    input  logic deassert_i,
    input  logic clr_i,
    output logic pend_o
);
    intx_state_e state_q;
    intx_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            INTX_IDLE: begin
                if (assert_i) state_d = INTX_ACTIVE;
            end
            INTX_ACTIVE: begin
                if (deassert_i && !assert_i) state_d = INTX_RELEASED;
            end
            INTX_RELEASED: begin
                if (assert_i)      state_d = INTX_ACTIVE;
                else if (clr_i)    state_d = INTX_IDLE;
            end
            default: state_d = INTX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= INTX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pend_o = (state_q != INTX_IDLE);
    end

    AST_INTX_HELD_WHILE_ASSERTED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == INTX_ACTIVE && !deassert_i) |=> pend_o); // R5
    AST_INTX_FALL_NEEDS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend_o) |-> $past(state_q == INTX_RELEASED && clr_i)); // R5
endmodule

// File: rtl/irqagg_top_ctrl.sv
module irqagg_top_ctrl
    import irqagg_pkg::*;
#(
    parameter int NUM_GRP  = 8,
    parameter int NUM_INTX = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_GRP-1:0]  grp_live_i,
    input  logic [NUM_INTX-1:0] intx_pend_i,
    input  logic [NUM_EVT-1:0]  evt_i,
    input  logic                en_wr_i,
    input  logic                stat_w1c_i,
    input  logic [DATA_W-1:0]   wdata_i,
    output logic [NUM_INTX-1:0] intx_clr_o,
    output logic [DATA_W-1:0]   top_en_o,
    output logic [DATA_W-1:0]   top_stat_o,
    output logic                irq_o
);
    localparam logic [DATA_W-1:0] EN_MASK =
        (((DATA_W'(1) << NUM_GRP)  - 1) << SUM_LSB)  |
        (((DATA_W'(1) << NUM_INTX) - 1) << INTX_LSB) |
        (((DATA_W'(1) << NUM_EVT)  - 1) << EVT_LSB);

    logic [NUM_GRP-1:0] sum_q;
    logic [NUM_EVT-1:0] evt_q;
    logic [DATA_W-1:0]  en_q;
    logic [DATA_W-1:0]  clr_w;

    assign clr_w = stat_w1c_i ? (wdata_i & EN_MASK) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
            evt_q <= '0;
            en_q  <= '0;
        end else begin
            sum_q <= grp_live_i | (sum_q & ~clr_w[SUM_LSB +: NUM_GRP]);
            evt_q <= evt_i | (evt_q & ~clr_w[EVT_LSB +: NUM_EVT]);
            if (en_wr_i) en_q <= wdata_i & EN_MASK;
        end
    end

    always_comb begin
        top_stat_o = '0;
        top_stat_o[SUM_LSB  +: NUM_GRP]  = sum_q;
        top_stat_o[INTX_LSB +: NUM_INTX] = intx_pend_i;
        top_stat_o[EVT_LSB  +: NUM_EVT]  = evt_q;
        intx_clr_o = clr_w[INTX_LSB +: NUM_INTX];
        top_en_o   = en_q;
        irq_o      = |(top_stat_o & en_q);
    end

    AST_SUMMARY_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_live_i != '0) |=> ((sum_q & $past(grp_live_i)) == $past(grp_live_i))); // R4
    AST_EVENT_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((evt_q & $past(evt_i)) == $past(evt_i))); // R6
    AST_NO_IRQ_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq_o); // R7
endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
    import irqagg_pkg::*;
#(
    parameter int NUM_GRP     = 8,
    parameter int VEC_PER_GRP = 32,
    parameter int NUM_INTX    = 4,
    parameter int GRP_W       = $clog2(NUM_GRP),
    parameter int BIT_W       = $clog2(VEC_PER_GRP),
    parameter int VEC_W       = GRP_W + BIT_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr_i,
    input  logic                reg_rd_i,
    input  logic [ADDR_W-1:0]   reg_addr_i,
    input  logic [DATA_W-1:0]   reg_wdata_i,
    output logic [DATA_W-1:0]   reg_rdata_o,
    input  logic                msi_valid_i,
    input  logic [VEC_W-1:0]    msi_vector_i,
    input  logic [NUM_INTX-1:0] intx_assert_i,
    input  logic [NUM_INTX-1:0] intx_deassert_i,
    input  logic                evt_msg_i,
    input  logic                evt_aer_i,
    input  logic                evt_pm_i,
    output logic                irq_o
);
    localparam logic [ADDR_W-1:0] GRP_END =
        OFS_GRP_BASE + ADDR_W'(NUM_GRP << GRP_STRIDE_LG2);

    // ---------------- address decode ----------------
    logic              in_grp;
    logic [ADDR_W-1:0] grp_rel;
    logic [GRP_W-1:0]  grp_sel;
    grp_word_e         grp_word;
    logic              hit_top_en, hit_top_stat, hit_grp_en, rd_hit;

    always_comb begin
        grp_rel  = reg_addr_i - OFS_GRP_BASE;
        grp_sel  = grp_rel[GRP_STRIDE_LG2 +: GRP_W];
        in_grp   = (reg_addr_i >= OFS_GRP_BASE) && (reg_addr_i < GRP_END) &&
                   (reg_addr_i[1:0] == 2'b00);
        grp_word = in_grp ? grp_word_e'(reg_addr_i[3:2]) : GW_NONE;
        hit_top_en   = (reg_addr_i == OFS_TOP_EN);
        hit_top_stat = (reg_addr_i == OFS_TOP_STAT);
        hit_grp_en   = (reg_addr_i == OFS_GRP_EN);
        rd_hit = hit_top_en || hit_top_stat || hit_grp_en || (grp_word != GW_NONE);
    end

    // ---------------- group enable ----------------
    logic [NUM_GRP-1:0] grp_en_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       grp_en_q <= '0;
        else if (reg_wr_i && hit_grp_en)  grp_en_q <= reg_wdata_i[NUM_GRP-1:0];
    end

    // ---------------- MSI groups ----------------
    logic [NUM_GRP-1:0][DATA_W-1:0]      g_addr;
    logic [NUM_GRP-1:0][VEC_PER_GRP-1:0] g_pend;
    logic [NUM_GRP-1:0][VEC_PER_GRP-1:0] g_ven;
    logic [NUM_GRP-1:0]                  g_live;
    logic [GRP_W-1:0]                    msi_grp;
    logic [BIT_W-1:0]                    msi_bit;

    assign msi_grp = msi_vector_i[BIT_W +: GRP_W];
    assign msi_bit = msi_vector_i[BIT_W-1:0];

    for (genvar g = 0; g < NUM_GRP; g++) begin : gen_grp
        irqagg_msi_group #(
            .VEC_PER_GRP (VEC_PER_GRP),
            .BIT_W       (BIT_W)
        ) grp_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .hit_i     (msi_valid_i && msi_grp == GRP_W'(g)),
            .bit_i     (msi_bit),
            .wr_sel_i  (reg_wr_i && in_grp && grp_sel == GRP_W'(g)),
            .wr_word_i (grp_word),
            .wdata_i   (reg_wdata_i),
            .addr_o    (g_addr[g]),
            .pend_o    (g_pend[g]),
            .ven_o     (g_ven[g]),
            .live_o    (g_live[g])
        );
    end

    // ---------------- legacy lines ----------------
    logic [NUM_INTX-1:0] intx_pend;
    logic [NUM_INTX-1:0] intx_clr;

    for (genvar n = 0; n < NUM_INTX; n++) begin : gen_intx
        irqagg_intx_fsm intx_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .assert_i   (intx_assert_i[n]),
            .deassert_i (intx_deassert_i[n]),
            .clr_i      (intx_clr[n]),
            .pend_o     (intx_pend[n])
        );
    end

    // ---------------- top level ----------------
    logic [DATA_W-1:0] top_en, top_stat;

    irqagg_top_ctrl #(
        .NUM_GRP  (NUM_GRP),
        .NUM_INTX (NUM_INTX)
    ) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .grp_live_i  (g_live & grp_en_q),
        .intx_pend_i (intx_pend),
        .evt_i       ({evt_pm_i, evt_aer_i, evt_msg_i}),
        .en_wr_i     (reg_wr_i && hit_top_en),
        .stat_w1c_i  (reg_wr_i && hit_top_stat),
        .wdata_i     (reg_wdata_i),
        .intx_clr_o  (intx_clr),
        .top_en_o    (top_en),
        .top_stat_o  (top_stat),
        .irq_o       (irq_o)
    );

    // ---------------- read path ----------------
    logic [DATA_W-1:0] rd_val;
    always_comb begin
        rd_val = '0;
        if (hit_top_en)        rd_val = top_en;
        else if (hit_top_stat) rd_val = top_stat;
        else if (hit_grp_en)   rd_val = DATA_W'(grp_en_q);
        else begin
            unique case (grp_word)
                GW_ADDR: rd_val = g_addr[grp_sel];
                GW_PEND: rd_val = DATA_W'(g_pend[grp_sel]);
                GW_VEN:  rd_val = DATA_W'(g_ven[grp_sel]);
                GW_NONE: rd_val = '0;
                default: rd_val = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        reg_rdata_o <= '0;
        else if (reg_rd_i) reg_rdata_o <= rd_val;
    end

    AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_i && !rd_hit) |=> (reg_rdata_o == '0)); // R9
    AST_DISABLED_GROUP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_en_q == '0 && $past(grp_en_q) == '0 && top_stat[SUM_LSB +: NUM_GRP] == '0)
        |=> (top_stat[SUM_LSB +: NUM_GRP] == '0)); // R4
endmodule

// File: tb/irqagg_top_tb_top.sv
module irqagg_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        msi_valid = 1'b0;
    logic [7:0]  msi_vector = '0;
    logic [3:0]  intx_as = '0, intx_de = '0;
    logic        ev_msg = 1'b0, ev_aer = 1'b0, ev_pm = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irqagg_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .msi_valid_i(msi_valid), .msi_vector_i(msi_vector),
        .intx_assert_i(intx_as), .intx_deassert_i(intx_de),
        .evt_msg_i(ev_msg), .evt_aer_i(ev_aer), .evt_pm_i(ev_pm),
        .irq_o(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic msi(input logic [7:0] v);
        msi_valid = 1'b1; msi_vector = v;
        @(negedge clk);
        msi_valid = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R8 irq after reset", {31'b0, irq}, 32'h0);
        rd(12'h184, d); chk("R8 top status reset", d, 32'h0);
        rd(12'h180, d); chk("R8 top enable reset", d, 32'h0);
        rd(12'hC04, d); chk("R8 group0 pending reset", d, 32'h0);
        rd(12'hC78, d); chk("R3 group7 enable reset", d, 32'h0);
    endtask

    task automatic t_group_regs;
        logic [31:0] d;
        wr(12'hC10, 32'hDEAD_BEE0);
        rd(12'hC10, d); chk("R3 group1 address", d, 32'hDEAD_BEE0);
        wr(12'hC18, 32'hFFFF_0000);
        rd(12'hC18, d); chk("R3 group1 enable", d, 32'hFFFF_0000);
        rd(12'hC00, d); chk("R3 group0 address untouched", d, 32'h0);
    endtask

    task automatic t_msi_decode;
        logic [31:0] d;
        msi(8'd37);
        rd(12'hC14, d); chk("R1 vector 37 -> group1 bit5", d, 32'h0000_0020);
        msi(8'd255);
        rd(12'hC74, d); chk("R1 vector 255 -> group7 bit31", d, 32'h8000_0000);
        msi(8'd0);
        rd(12'hC04, d); chk("R1 vector 0 -> group0 bit0", d, 32'h0000_0001);
        wr(12'hC74, 32'h8000_0000);
        rd(12'hC74, d); chk("R2 pending clear", d, 32'h0);
    endtask

    task automatic t_summary;
        logic [31:0] d;
        wr(12'h180, 32'h0000_FF00);
        wr(12'hC18, 32'h0000_0020);
        idle(2);
        rd(12'h184, d); chk("R4 gated by group enable", d, 32'h0);
        chk("R7 irq low while gated", {31'b0, irq}, 32'h0);
        wr(12'h190, 32'h0000_0002);
        idle(2);
        rd(12'h184, d); chk("R4 summary bit 9 set", d, 32'h0000_0200);
        chk("R7 irq high", {31'b0, irq}, 32'h1);
        wr(12'h184, 32'h0000_0200);
        idle(1);
        rd(12'h184, d); chk("R4 clear ignored while pending", d, 32'h0000_0200);
        wr(12'hC14, 32'h0000_0020);
        idle(2);
        rd(12'h184, d); chk("R4 summary sticky after service", d, 32'h0000_0200);
        wr(12'h184, 32'h0000_0200);
        idle(1);
        rd(12'h184, d); chk("R4 summary clears after service", d, 32'h0);
        chk("R7 irq drops", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_collide;
        logic [31:0] d;
        msi(8'd37);
        msi_valid = 1'b1; msi_vector = 8'd37;
        reg_wr = 1'b1; reg_addr = 12'hC14; reg_wdata = 32'h0000_0020;
        @(negedge clk);
        msi_valid = 1'b0; reg_wr = 1'b0;
        rd(12'hC14, d); chk("R2 set wins over clear", d, 32'h0000_0020);
        wr(12'hC14, 32'h0000_0020);
        rd(12'hC14, d); chk("R2 clear alone", d, 32'h0);
        idle(1);
        wr(12'h184, 32'h0000_0200);
        rd(12'h184, d); chk("R4 tidy summary", d, 32'h0);
    endtask

    task automatic t_intx;
        logic [31:0] d;
        wr(12'h180, 32'h0F00_0000);
        intx_as = 4'b0010; @(negedge clk); intx_as = '0;
        chk("R5 line B raises irq", {31'b0, irq}, 32'h1);
        rd(12'h184, d); chk("R5 line B bit25", d, 32'h0200_0000);
        wr(12'h184, 32'h0200_0000);
        rd(12'h184, d); chk("R5 clear ignored while asserted", d, 32'h0200_0000);
        intx_de = 4'b0010; @(negedge clk); intx_de = '0;
        rd(12'h184, d); chk("R5 deassert alone keeps bit", d, 32'h0200_0000);
        wr(12'h184, 32'h0200_0000);
        rd(12'h184, d); chk("R5 clear after deassert", d, 32'h0);
        chk("R7 irq low after intx clear", {31'b0, irq}, 32'h0);
        intx_de = 4'b1000; @(negedge clk); intx_de = '0;
        rd(12'h184, d); chk("R5 deassert on idle line", d, 32'h0);
    endtask

    task automatic t_mask;
        logic [31:0] d;
        wr(12'h180, 32'h0);
        intx_as = 4'b0001; @(negedge clk); intx_as = '0;
        chk("R7 masked line keeps irq low", {31'b0, irq}, 32'h0);
        rd(12'h184, d); chk("R5 line A bit24", d, 32'h0100_0000);
        wr(12'h180, 32'hFFFF_FFFF);
        rd(12'h180, d); chk("R7 enable stores only defined bits", d, 32'h7F00_FF00);
        chk("R7 unmask raises irq", {31'b0, irq}, 32'h1);
        intx_de = 4'b0001; @(negedge clk); intx_de = '0;
        wr(12'h184, 32'h0100_0000);
        chk("R7 irq low after release+clear", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_events;
        logic [31:0] d;
        ev_aer = 1'b1; @(negedge clk); ev_aer = 1'b0;
        rd(12'h184, d); chk("R6 error event bit29", d, 32'h2000_0000);
        chk("R7 irq on event", {31'b0, irq}, 32'h1);
        ev_aer = 1'b1; reg_wr = 1'b1; reg_addr = 12'h184; reg_wdata = 32'h2000_0000;
        @(negedge clk);
        ev_aer = 1'b0; reg_wr = 1'b0;
        rd(12'h184, d); chk("R6 event wins over clear", d, 32'h2000_0000);
        ev_msg = 1'b1; ev_pm = 1'b1; @(negedge clk); ev_msg = 1'b0; ev_pm = 1'b0;
        rd(12'h184, d); chk("R6 message and pm bits", d, 32'h7000_0000);
        wr(12'h184, 32'h7000_0000);
        rd(12'h184, d); chk("R6 events cleared", d, 32'h0);
    endtask

    task automatic t_unmapped;
        logic [31:0] d;
        wr(12'h190, 32'h0000_0081);
        wr(12'hC80, 32'h1234_5678);
        rd(12'hC80, d); chk("R9 beyond last group reads zero", d, 32'h0);
        wr(12'hC0C, 32'hFFFF_FFFF);
        rd(12'hC0C, d); chk("R9 word 3 of a group reads zero", d, 32'h0);
        wr(12'h188, 32'hFFFF_FFFF);
        rd(12'h190, d); chk("R9 group enable intact", d, 32'h0000_0081);
        rd(12'hC08, d); chk("R9 group0 enable intact", d, 32'h0);
        rd(12'h100, d); chk("R9 unmapped 0x100 reads zero", d, 32'h0);
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_group_regs();
        t_msi_decode();
        t_summary();
        t_collide();
        t_intx();
        t_mask();
        t_events();
        t_unmapped();
        done = 1'b1;
        finish_run();
    end
endmodule